// File: doc/BRIEF.md
# Spare-Column Fault Avoidance Remapper

This block holds the repair state for one tile array. The array is a grid of normal tiles with one extra column of spare tiles on its right-hand edge. While the array is healthy, logical column L sits on physical column L and the spare column stays idle. When a faulty column index is committed, every logical column at or to the right of that index moves one physical place right. The last logical column then lands in the spare. This keeps the fabric usable without re-placing the whole design.

The block drives three groups of outputs from a single registered repair state:

- **Bypass selectors.** One selector per single-wire horizontal segment per row. The selectors route around the skipped tile.
- **Interface selectors.** Two selectors at the array's left and right edges. They keep inter-array wiring aligned with the shifted columns.
- **Mapping table.** The physical column for each logical column.

Repairs are requested by pulsing an update strobe:

- The strobe together with a valid flag and a column index requests a repair.
- The strobe with the valid flag low restores the unrepaired mapping.
- Only one faulty column can be absorbed. A second, different fault is reported on a sticky unrecoverable flag, and the existing repair stays in place.

Top module: `spare_col_remap`

## Requirements
- R1: After reset the mapping is the identity and all bypass and interface selectors are 0. The spare indicator and the unrecoverable flag are also 0.
- R2: A strobe with faultValid=1 and faultCol=f < NUM_COLS, when no repair is active, sets the mapping from the next clock edge. Logical column L maps to physical L for L<f and to L+1 for L>=f. The mapping table packs logical column L in bits [L*COL_W +: COL_W].
- R3: segBypass bit r*NUM_COLS+c is 1 exactly when a repair is active at column c. This holds for every row r.
- R4: spareActive is 1 exactly when a repair is active.
- R5: rightIfSel is 1 whenever a repair is active, so the right-edge link comes from the spare column. leftIfSel is 1 only when the repaired column is 0.
- R6: Without a strobe, faultValid and faultCol have no effect on any output.
- R7: A strobe carrying a valid in-range column different from the active one sets unrecoverable and leaves the mapping unchanged. The same column again changes nothing.
- R8: A strobe with faultValid=0 restores the R1 state, including clearing unrecoverable.
- R9: A strobe carrying faultCol >= NUM_COLS (including the spare column's own index) changes no output.
- R10: All outputs change together on the clock edge that samples the strobe, and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| updateStrobe | input | 1 | Applies the request on this cycle |
| faultValid | input | 1 | 1: report a fault; 0: clear the repair |
| faultCol | input | COL_W | Faulty column index |
| mapTable | output | NUM_COLS*COL_W | Physical column per logical column |
| segBypass | output | NUM_ROWS*NUM_COLS | Per-row, per-column segment bypass selects |
| spareActive | output | 1 | Spare column carries logic |
| leftIfSel | output | 1 | Left interface taps physical column 1 |
| rightIfSel | output | 1 | Right interface taps the spare column |
| unrecoverable | output | 1 | Sticky second-fault indicator |

## Verification
Two functions can fall on the same clock edge: reporting a fault on a column other than the active one, and holding the existing repair. The unrecoverable flag must rise on the same edge at which the mapping is required to stay frozen. The bench provokes this by committing column 2 and then striking column 0, and later by committing column 3 and then striking column 1 after a strobe-less cycle. Each case is judged by comparing the full mapping table, bypass vector, interface selects and flag against values derived from the requirements, one cycle after the strobe.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;

  // Strobes from the decision logic to the state/mapping path.
  typedef struct packed {
    logic commitFault;  // take a new repair column
    logic clearAll;     // drop the repair and the sticky flag
    logic flagSecond;   // record an unrepairable second fault
  } remap_ctrl_t;

endpackage

// File: rtl/spare_remap_ctrl.sv
module spare_remap_ctrl
  import spare_remap_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int COL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             updateStrobe,
  input  logic             faultValid,
  input  logic [COL_W-1:0] faultCol,
  input  logic             activeValid,
  input  logic [COL_W-1:0] activeCol,
  output remap_ctrl_t      ctrlOut
);

  logic inRange;
  logic faultReq;

  assign inRange  = faultCol < COL_W'(NUM_COLS);
  assign faultReq = updateStrobe && faultValid && inRange;

  always_comb begin
    ctrlOut             = '0;
    ctrlOut.clearAll    = updateStrobe && !faultValid;
    ctrlOut.commitFault = faultReq && !activeValid;
    ctrlOut.flagSecond  = faultReq && activeValid && (faultCol != activeCol);
  end

  // R9: an out-of-range index never moves the repair state.
  assert_ignore_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (updateStrobe && faultValid && !inRange)
      |=> ($stable(activeValid) && $stable(activeCol)));

  // R7: a repeated report of the active column leaves the state alone.
  assert_same_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (updateStrobe && faultValid && activeValid && faultCol == activeCol)
      |=> ($stable(activeValid) && $stable(activeCol)));

endmodule

// File: rtl/spare_remap_path.sv
module spare_remap_path
  import spare_remap_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int COL_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  remap_ctrl_t                 ctrlIn,
  input  logic [COL_W-1:0]            newCol,
  output logic                        activeValid,
  output logic [COL_W-1:0]            activeCol,
  output logic [NUM_COLS*COL_W-1:0]   mapTable,
  output logic [NUM_ROWS*NUM_COLS-1:0] segBypass,
  output logic                        spareActive,
  output logic                        leftIfSel,
  output logic                        rightIfSel,
  output logic                        unrecoverable
);

  // Single repair state: every output is decoded from these registers,
  // so a commit becomes visible everywhere on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeValid   <= 1'b0;
      activeCol     <= '0;
      unrecoverable <= 1'b0;
    end else if (ctrlIn.clearAll) begin
      activeValid   <= 1'b0;
      activeCol     <= '0;
      unrecoverable <= 1'b0;
    end else if (ctrlIn.commitFault) begin
      activeValid   <= 1'b1;
      activeCol     <= newCol;
    end else if (ctrlIn.flagSecond) begin
      unrecoverable <= 1'b1;
    end
  end

  // Logical-to-physical column map.
  for (genvar lc = 0; lc < NUM_COLS; lc++) begin : g_map
    assign mapTable[lc*COL_W +: COL_W] =
      (activeValid && (COL_W'(lc) >= activeCol)) ? COL_W'(lc + 1) : COL_W'(lc);
  end

  // Bypass selectors on each row's single-wire segments.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign segBypass[r*NUM_COLS + c] = activeValid && (activeCol == COL_W'(c));
    end
  end

  assign spareActive = activeValid;
  assign rightIfSel  = activeValid;
  assign leftIfSel   = activeValid && (activeCol == '0);

  // R6 / R10: the repair state moves only after a strobe from control.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrlIn.commitFault) && !$past(ctrlIn.clearAll) && !$past(ctrlIn.flagSecond))
      |-> ($stable(activeValid) && $stable(activeCol) && $stable(unrecoverable)));

  // R3: at most one column per row is bypassed.
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(segBypass[NUM_COLS-1:0]));

  // R7: the sticky flag can only stand on top of an existing repair.
  assert_unrec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |-> activeValid);

  // R7: a rising flag never disturbs the repaired column.
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unrecoverable) |-> $stable(activeCol));

  // R8: a clear always drops the flag.
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrlIn.clearAll) |-> (!unrecoverable && !spareActive));

  // R2: the map stays strictly increasing.
  for (genvar m = 0; m + 1 < NUM_COLS; m++) begin : g_mono
    assert_mono_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mapTable[(m+1)*COL_W +: COL_W] > mapTable[m*COL_W +: COL_W]);
  end

  // R4: the last logical column sits in the spare exactly when the spare is in use.
  assert_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spareActive == (mapTable[(NUM_COLS-1)*COL_W +: COL_W] == COL_W'(NUM_COLS)));

endmodule

// File: rtl/spare_col_remap.sv
module spare_col_remap
  import spare_remap_pkg::*;
#(
  parameter  int NUM_ROWS = 4,
  parameter  int NUM_COLS = 4,
  localparam int COL_W    = $clog2(NUM_COLS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         updateStrobe,
  input  logic                         faultValid,
  input  logic [COL_W-1:0]             faultCol,
  output logic [NUM_COLS*COL_W-1:0]    mapTable,
  output logic [NUM_ROWS*NUM_COLS-1:0] segBypass,
  output logic                         spareActive,
  output logic                         leftIfSel,
  output logic                         rightIfSel,
  output logic                         unrecoverable
);

  remap_ctrl_t      ctrlBus;
  logic             activeValid;
  logic [COL_W-1:0] activeCol;

  spare_remap_ctrl #(
    .NUM_COLS(NUM_COLS),
    .COL_W   (COL_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .updateStrobe(updateStrobe),
    .faultValid  (faultValid),
    .faultCol    (faultCol),
    .activeValid (activeValid),
    .activeCol   (activeCol),
    .ctrlOut     (ctrlBus)
  );

  spare_remap_path #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_COLS(NUM_COLS),
    .COL_W   (COL_W)
  ) u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrlIn       (ctrlBus),
    .newCol       (faultCol),
    .activeValid  (activeValid),
    .activeCol    (activeCol),
    .mapTable     (mapTable),
    .segBypass    (segBypass),
    .spareActive  (spareActive),
    .leftIfSel    (leftIfSel),
    .rightIfSel   (rightIfSel),
    .unrecoverable(unrecoverable)
  );

endmodule

// File: tb/spare_col_remap_bench.sv
module spare_col_remap_bench;

  localparam int NR = 4;
  localparam int NC = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          updateStrobe = 1'b0;
  logic          faultValid = 1'b0;
  logic [CW-1:0] faultCol = '0;
  logic [NC*CW-1:0] mapTable;
  logic [NR*NC-1:0] segBypass;
  logic spareActive, leftIfSel, rightIfSel, unrecoverable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spare_col_remap #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_spare_col_remap (
    .clk(clk), .rst_n(rst_n), .updateStrobe(updateStrobe),
    .faultValid(faultValid), .faultCol(faultCol), .mapTable(mapTable),
    .segBypass(segBypass), .spareActive(spareActive), .leftIfSel(leftIfSel),
    .rightIfSel(rightIfSel), .unrecoverable(unrecoverable)
  );

  // Vector: {strobe, valid, col[2:0], expActive, expCol[2:0], expUnrec}
  localparam logic [9:0] VEC [13] = '{
    {1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0},  // R6 no strobe
    {1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 1'b0},  // R2 commit col 2
    {1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 1'b0},  // R7 same column
    {1'b1, 1'b1, 3'd0, 1'b1, 3'd2, 1'b1},  // R7 second fault
    {1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},  // R8 clear
    {1'b1, 1'b1, 3'd5, 1'b0, 3'd0, 1'b0},  // R9 out of range
    {1'b1, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0},  // R5 col 0 -> left interface
    {1'b1, 1'b1, 3'd4, 1'b1, 3'd0, 1'b0},  // R9 spare index
    {1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},  // R8 clear
    {1'b1, 1'b1, 3'd3, 1'b1, 3'd3, 1'b0},  // R2 last column
    {1'b0, 1'b1, 3'd1, 1'b1, 3'd3, 1'b0},  // R6 no strobe
    {1'b1, 1'b1, 3'd1, 1'b1, 3'd3, 1'b1},  // R7 second fault
    {1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0}   // R8 clear
  };

  function automatic logic [NC*CW-1:0] expMap(bit act, int col);
    logic [NC*CW-1:0] m = '0;
    for (int l = 0; l < NC; l++)
      m[l*CW +: CW] = (act && l >= col) ? CW'(l + 1) : CW'(l);
    return m;
  endfunction

  function automatic logic [NR*NC-1:0] expBypass(bit act, int col);
    logic [NR*NC-1:0] b = '0;
    if (act)
      for (int r = 0; r < NR; r++) b[r*NC + col] = 1'b1;
    return b;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req, bit act, int col, bit unrec);
    check(req, "mapTable",      int'(mapTable),      int'(expMap(act, col)));
    check(req, "segBypass",     int'(segBypass),     int'(expBypass(act, col)));
    check(req, "spareActive",   int'(spareActive),   int'(act));
    check(req, "rightIfSel",    int'(rightIfSel),    int'(act));
    check(req, "leftIfSel",     int'(leftIfSel),     int'(act && col == 0));
    check(req, "unrecoverable", int'(unrecoverable), int'(unrec));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1", 1'b0, 0, 1'b0);

    for (int i = 0; i < 13; i++) begin
      updateStrobe = VEC[i][9];
      faultValid   = VEC[i][8];
      faultCol     = VEC[i][7:5];
      @(negedge clk);
      updateStrobe = 1'b0;
      checkAll($sformatf("R2-vec%0d", i), VEC[i][4], int'(VEC[i][3:1]), VEC[i][0]);
    end

    // R10: nothing moves before the sampling edge, everything after it.
    faultValid = 1'b1; faultCol = 3'd1; updateStrobe = 1'b1;
    #4;
    checkAll("R10", 1'b0, 0, 1'b0);
    @(negedge clk);
    updateStrobe = 1'b0;
    checkAll("R10", 1'b1, 1, 1'b0);

    // R6: inputs toggle for several cycles without a strobe.
    faultCol = 3'd0;
    repeat (3) @(negedge clk);
    faultValid = 1'b0;
    @(negedge clk);
    checkAll("R6", 1'b1, 1, 1'b0);

    // R1: reset mid-operation returns to identity.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1", 1'b0, 0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule